// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block keeps the global configuration and the accumulated exception state of a scalar floating-point unit. It stores a 3-bit dynamic rounding mode and five sticky exception flags. Software reaches the state through one of three views picked by a select input: the whole register, the rounding mode alone, or the flags alone. Each view can be read combinationally and written on a clock edge.

Every floating-point instruction presents its own 3-bit rounding field. The block returns the rounding mode that instruction must use. A field value of 111 defers to the stored dynamic mode, and any other value is used as it stands. When the result is a reserved code, the block raises an illegal-instruction indication. Operations that complete report their exception flags on a valid strobe. Those flags are ORed into the stored flags, and hardware never clears them.

Top module: `fp_csr_unit`

## Requirements
- R1: After reset the stored rounding mode is 000 (round to nearest, ties to even) and all five flags are 0.
- R2: View select 00 (full view) reads as zeros in bits 31:8, the rounding mode in bits 7:5 and the flags in bits 4:0. A write in this view loads the mode from bits 7:5 and the flags from bits 4:0, and the new value is visible after the next rising clock edge.
- R3: View select 01 (mode view) reads the mode zero-extended. A write in this view loads the mode from bits 2:0 and leaves the flags untouched by software.
- R4: View select 10 (flags view) reads the flags zero-extended. A write in this view loads the flags from bits 4:0 and leaves the mode unchanged.
- R5: View select 11 reads as zero, and a write with it changes neither the mode nor the flags.
- R6: Mode codes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest with ties to max magnitude. In the same cycle, the effective mode output equals the instruction rounding field, or equals the stored mode when that field is 111.
- R7: The illegal-rounding output is 1 exactly when the effective mode is 101, 110 or 111, and 0 when it is 000 to 100.
- R8: When the hardware flag strobe is high, the reported flags (bit 4 invalid, bit 3 divide by zero, bit 2 overflow, bit 1 underflow, bit 0 inexact) are ORed into the stored flags at the next rising edge.
- R9: A hardware flag report never clears a stored flag, including a report of all zeros.
- R10: When a software write in the full view or the flags view coincides with a hardware flag report, the stored flags take the written value alone. When a write in the mode view coincides with a report, the report is still ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_wr_i | input | 1 | Software write strobe |
| sw_view_i | input | 2 | View select: 00 full, 01 mode, 10 flags, 11 none |
| sw_wdata_i | input | 32 | Software write data |
| sw_rdata_o | output | 32 | Read data of the selected view |
| hw_flag_valid_i | input | 1 | A completing operation reports flags |
| hw_flags_i | input | 5 | Reported exception flags |
| instr_rm_i | input | 3 | Instruction rounding field (111 selects the dynamic mode) |
| eff_rm_o | output | 3 | Effective rounding mode for the instruction |
| rm_illegal_o | output | 1 | Effective rounding mode is a reserved code |
| mode_o | output | 3 | Stored dynamic rounding mode |
| flags_o | output | 5 | Stored sticky flags |

## Verification
The effective mode, the illegal indication and the read data are combinational, so they are due in the same cycle as the instruction field or view select that produces them. The bench changes those inputs and samples after one time unit of settling. Mode and flag updates land on the rising edge after the write or the flag strobe. The bench drives each such stimulus one time unit after an edge, waits for the following edge and samples one time unit later. It then sweeps all 64 pairs of stored mode and instruction field, and 32 patterns of paired flag reports.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
    localparam int unsigned RM_W   = 3;
    localparam int unsigned FLAG_W = 5;

    localparam logic [RM_W-1:0] RM_RNE = 3'b000;
    localparam logic [RM_W-1:0] RM_RTZ = 3'b001;
    localparam logic [RM_W-1:0] RM_RDN = 3'b010;
    localparam logic [RM_W-1:0] RM_RUP = 3'b011;
    localparam logic [RM_W-1:0] RM_RMM = 3'b100;
    localparam logic [RM_W-1:0] RM_DYN = 3'b111;

    typedef enum logic [1:0] {
        VIEW_FULL  = 2'b00,
        VIEW_MODE  = 2'b01,
        VIEW_FLAGS = 2'b10,
        VIEW_NONE  = 2'b11
    } view_e;

    typedef struct packed {
        logic [RM_W-1:0]   mode;
        logic [FLAG_W-1:0] flags;
    } csr_state_t;
endpackage

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
    import fpcsr_pkg::*;
(
    input  logic [RM_W-1:0] instr_rm_i,
    input  logic [RM_W-1:0] dyn_rm_i,
    output logic [RM_W-1:0] eff_rm_o,
    output logic            illegal_o
);
    always_comb begin
        eff_rm_o = (instr_rm_i == RM_DYN) ? dyn_rm_i : instr_rm_i;
        illegal_o = (eff_rm_o > RM_RMM);
    end
endmodule

// File: rtl/fpcsr_view_mux.sv
module fpcsr_view_mux
    import fpcsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        view_i,
    input  csr_state_t        state_i,
    output logic [DATA_W-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        unique case (view_e'(view_i))
            VIEW_FULL:  rdata_o[RM_W+FLAG_W-1:0] = state_i;
            VIEW_MODE:  rdata_o[RM_W-1:0]        = state_i.mode;
            VIEW_FLAGS: rdata_o[FLAG_W-1:0]      = state_i.flags;
            default:    rdata_o                  = '0;
        endcase
    end
endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit
    import fpcsr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sw_wr_i,
    input  logic [1:0]        sw_view_i,
    input  logic [DATA_W-1:0] sw_wdata_i,
    output logic [DATA_W-1:0] sw_rdata_o,
    input  logic              hw_flag_valid_i,
    input  logic [FLAG_W-1:0] hw_flags_i,
    input  logic [RM_W-1:0]   instr_rm_i,
    output logic [RM_W-1:0]   eff_rm_o,
    output logic              rm_illegal_o,
    output logic [RM_W-1:0]   mode_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam int unsigned MODE_LSB = FLAG_W;
    localparam int unsigned MODE_MSB = FLAG_W + RM_W - 1;

    csr_state_t st_d, st_q;
    logic       flag_sw_wr;
    logic       unused_wdata_hi;

    assign unused_wdata_hi = ^sw_wdata_i[DATA_W-1:MODE_MSB+1];

    always_comb begin
        st_d       = st_q;
        flag_sw_wr = sw_wr_i && ((view_e'(sw_view_i) == VIEW_FULL) ||
                                 (view_e'(sw_view_i) == VIEW_FLAGS));
        if (hw_flag_valid_i && !flag_sw_wr) begin
            st_d.flags = st_q.flags | hw_flags_i;
        end
        if (sw_wr_i) begin
            unique case (view_e'(sw_view_i))
                VIEW_FULL: begin
                    st_d.mode  = sw_wdata_i[MODE_MSB:MODE_LSB];
                    st_d.flags = sw_wdata_i[FLAG_W-1:0];
                end
                VIEW_MODE:  st_d.mode  = sw_wdata_i[RM_W-1:0];
                VIEW_FLAGS: st_d.flags = sw_wdata_i[FLAG_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: RM_RNE, flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    fpcsr_rm_resolve u_resolve (
        .instr_rm_i (instr_rm_i),
        .dyn_rm_i   (st_q.mode),
        .eff_rm_o   (eff_rm_o),
        .illegal_o  (rm_illegal_o)
    );

    fpcsr_view_mux #(.DATA_W(DATA_W)) u_rmux (
        .view_i  (sw_view_i),
        .state_i (st_q),
        .rdata_o (sw_rdata_o)
    );

    assign mode_o  = st_q.mode;
    assign flags_o = st_q.flags;
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker
    import fpcsr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sw_wr_i,
    input logic [1:0]        sw_view_i,
    input logic [RM_W-1:0]   wmode_i,
    input logic              hw_flag_valid_i,
    input logic [FLAG_W-1:0] hw_flags_i,
    input logic [RM_W-1:0]   instr_rm_i,
    input logic [RM_W-1:0]   eff_rm_o,
    input logic              rm_illegal_o,
    input logic [RM_W-1:0]   mode_o,
    input logic [FLAG_W-1:0] flags_o
);
    logic flag_wr;
    assign flag_wr = sw_wr_i && ((sw_view_i == 2'b00) || (sw_view_i == 2'b10));

    // R9
    flags_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !flag_wr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    // R8
    flags_accum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_flag_valid_i && !flag_wr) |=> ((flags_o & $past(hw_flags_i)) == $past(hw_flags_i)));

    // R3
    mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_wr_i && sw_view_i == 2'b01) |=> (mode_o == $past(wmode_i)));

    // R4
    mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_view_i == 2'b10 || sw_view_i == 2'b11 || !sw_wr_i) |=> $stable(mode_o));

    // R6
    static_rm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_rm_i != 3'b111) |-> (eff_rm_o == instr_rm_i));

    // R7
    legal_rm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (instr_rm_i <= 3'b100) |-> !rm_illegal_o);
endmodule

bind fp_csr_unit fpcsr_checker u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sw_wr_i         (sw_wr_i),
    .sw_view_i       (sw_view_i),
    .wmode_i         (sw_wdata_i[2:0]),
    .hw_flag_valid_i (hw_flag_valid_i),
    .hw_flags_i      (hw_flags_i),
    .instr_rm_i      (instr_rm_i),
    .eff_rm_o        (eff_rm_o),
    .rm_illegal_o    (rm_illegal_o),
    .mode_o          (mode_o),
    .flags_o         (flags_o)
);

// File: tb/fp_csr_unit_test.sv
module fp_csr_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [1:0]  sw_view = 2'b00;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        hw_v = 1'b0;
    logic [4:0]  hw_f = '0;
    logic [2:0]  instr_rm = 3'b111;
    logic [2:0]  eff_rm;
    logic        rm_ill;
    logic [2:0]  mode;
    logic [4:0]  flags;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_csr_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .sw_wr_i(sw_wr), .sw_view_i(sw_view),
        .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata), .hw_flag_valid_i(hw_v),
        .hw_flags_i(hw_f), .instr_rm_i(instr_rm), .eff_rm_o(eff_rm),
        .rm_illegal_o(rm_ill), .mode_o(mode), .flags_o(flags)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_write(input logic [1:0] v, input logic [31:0] d);
        sw_wr = 1'b1; sw_view = v; sw_wdata = d;
        step();
        sw_wr = 1'b0;
    endtask

    task automatic hw_report(input logic [4:0] f);
        hw_v = 1'b1; hw_f = f;
        step();
        hw_v = 1'b0;
    endtask

    task automatic read_view(input logic [1:0] v, output logic [31:0] d);
        sw_view = v;
        #1;
        d = sw_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [4:0]  acc;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 mode", {29'b0, mode}, 32'd0);
        check("R1 flags", {27'b0, flags}, 32'd0);
        read_view(2'b00, rd);
        check("R1 full read", rd, 32'd0);

        // R2 full view write and read
        sw_write(2'b00, 32'hFFFF_FF6B);
        read_view(2'b00, rd);
        check("R2 full read", rd, 32'h0000_006B);
        check("R2 mode", {29'b0, mode}, 32'd3);
        check("R2 flags", {27'b0, flags}, 32'h0B);

        // R3 mode view write leaves flags
        sw_write(2'b01, 32'hFFFF_FFF9);
        read_view(2'b01, rd);
        check("R3 mode read", rd, 32'd1);
        check("R3 flags kept", {27'b0, flags}, 32'h0B);

        // R4 flags view write leaves mode
        sw_write(2'b10, 32'hFFFF_FFF4);
        read_view(2'b10, rd);
        check("R4 flags read", rd, 32'h14);
        check("R4 mode kept", {29'b0, mode}, 32'd1);

        // R5 view 11 ignored
        sw_write(2'b11, 32'hFFFF_FFFF);
        read_view(2'b11, rd);
        check("R5 read zero", rd, 32'd0);
        read_view(2'b00, rd);
        check("R5 no change", rd, 32'h0000_0034);

        // R6 R7 exhaustive resolution sweep
        for (int m = 0; m < 8; m++) begin
            sw_write(2'b01, 32'(m));
            for (int r = 0; r < 8; r++) begin
                int e;
                instr_rm = 3'(r);
                #1;
                e = (r == 7) ? m : r;
                check("R6 effective mode", {29'b0, eff_rm}, 32'(e));
                check("R7 illegal", {31'b0, rm_ill}, (e >= 5) ? 32'd1 : 32'd0);
            end
        end
        instr_rm = 3'b111;

        // R8 R9 accumulation sweep
        for (int a = 0; a < 32; a++) begin
            logic [4:0] b;
            b = 5'((a * 7 + 3) % 32);
            sw_write(2'b10, 32'd0);
            hw_report(5'(a));
            check("R8 first report", {27'b0, flags}, 32'(a));
            hw_report(b);
            acc = 5'(a) | b;
            check("R8 OR of reports", {27'b0, flags}, {27'b0, acc});
            hw_report(5'd0);
            check("R9 zero report keeps", {27'b0, flags}, {27'b0, acc});
        end

        // R10 software write beats hardware report
        sw_write(2'b10, 32'h01);
        hw_v = 1'b1; hw_f = 5'h1E;
        sw_write(2'b10, 32'h02);
        hw_v = 1'b0;
        check("R10 flags view wins", {27'b0, flags}, 32'h02);
        hw_v = 1'b1; hw_f = 5'h10;
        sw_write(2'b00, 32'h0000_0041);
        hw_v = 1'b0;
        check("R10 full view wins", {27'b0, flags}, 32'h01);
        check("R10 full view mode", {29'b0, mode}, 32'd2);
        hw_v = 1'b1; hw_f = 5'h0C;
        sw_write(2'b01, 32'd4);
        hw_v = 1'b0;
        check("R10 mode view lets report in", {27'b0, flags}, 32'h0D);
        check("R10 mode view mode", {29'b0, mode}, 32'd4);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule